// File: doc/BRIEF.md
# Multi-Mode Address Generator

The block turns one access request per cycle into a byte address for a single load or store port. Each request names a pointer from a small private pointer file, an addressing mode, an offset or step, and an access width. The mode decides how the address is formed from the pointer and whether the pointer is updated afterwards. The available modes are: pointer plus immediate; pointer plus a stored modifier; post-increment; post-increment wrapping inside a circular window; and bit-reversed butterfly indexing for FFT passes. Two extra modes load a pointer or a modifier directly.

The address, its valid flag and an alignment error flag are registered and appear one clock after the request. When a pointer changes, the new value is shown on a write-back port in that same cycle and is committed to the pointer file on the following edge. A request issued in the next cycle that names the same pointer already sees the new value through forwarding. A port that needs its own address stream uses its own instance; instances share no state.

Top module: `agu_core`

## Requirements
- R1: After reset every pointer and every modifier reads as zero, and addrValid, alignErr and ptrWbValid are low.
- R2: Mode 0 (fixed) gives addrOut = pointer + reqOffset, with addrValid high one cycle after the request and no pointer write-back.
- R3: Mode 6 stores reqOffset into modifier entry reqPtrIdx and produces no address and no write-back. Mode 1 (indirect) gives addrOut = pointer + modifier[reqOffset[2:0]] and leaves the pointer unchanged.
- R4: Mode 2 (post-increment) gives addrOut = pointer and writes back pointer + reqOffset.
- R5: Mode 3 (cyclic) gives addrOut = pointer. It forms sum = pointer + step. When sum >= cycBase + cycSize, the pointer written back is sum - cycSize; otherwise it is sum. A cycSize of zero disables wrapping.
- R6: In mode 3, a step at least as large as cycSize is first reduced modulo cycSize, so a step equal to cycSize leaves the pointer unchanged.
- R7: Mode 4 (FFT) gives addrOut = cycBase + (pointer with its low fftLog2 bits reversed, upper bits dropped) shifted left by log2 of the access size. The pointer written back is (pointer + 1) masked to the low fftLog2 bits.
- R8: reqWidth 0/1/2/3 selects an access of 1/2/4/32 bytes. An address that is not a multiple of that size raises alignErr for one cycle, keeps addrValid low and suppresses the pointer write-back.
- R9: Mode 5 loads the pointer with reqOffset. Every pointer update appears on ptrWbValid/ptrWbIdx/ptrWbData one cycle after the request. A request in the very next cycle to the same pointer uses the updated value.
- R10: Mode 7 is ignored: no address, no error, no write-back, and no pointer or modifier changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 3 | Addressing mode (0..7) |
| reqPtrIdx | input | 3 | Pointer (or modifier) index |
| reqOffset | input | 20 | Offset, step or load value |
| reqWidth | input | 2 | Access size select |
| cycBase | input | 20 | Window base (cyclic) / table base (FFT) |
| cycSize | input | 20 | Window size in bytes (cyclic) |
| fftLog2 | input | 4 | Number of reversed bits, 0..10 |
| addrValid | output | 1 | Address valid |
| addrOut | output | 20 | Effective byte address |
| alignErr | output | 1 | Misaligned access flag |
| ptrWbValid | output | 1 | Pointer update strobe |
| ptrWbIdx | output | 3 | Updated pointer index |
| ptrWbData | output | 20 | Updated pointer value |

## Verification
Directed sequences first cover each mode in isolation. A cyclic walk over the window edge separates the wrap path from plain increment. Steps equal to and larger than the window show that the modulo reduction works, since a missing reduction leaves the pointer outside the window. A full FFT sweep with three reversed bits gives the known scrambled order and the return to zero. A misaligned post-increment followed by an aligned one on the same pointer shows whether the failed access leaked a write-back. The random phase issues back-to-back requests on a few pointers with mixed widths, so forwarding errors and stale reads show up as address mismatches.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    MODE_FIXED   = 3'd0,
    MODE_INDIR   = 3'd1,
    MODE_POSTINC = 3'd2,
    MODE_CYCLIC  = 3'd3,
    MODE_FFT     = 3'd4,
    MODE_SETPTR  = 3'd5,
    MODE_SETMOD  = 3'd6,
    MODE_NOP     = 3'd7
  } aguMode_e;

  typedef enum logic [1:0] {
    ADR_PTR_OFF = 2'd0,
    ADR_PTR_MOD = 2'd1,
    ADR_PTR     = 2'd2,
    ADR_FFT     = 2'd3
  } addrSel_e;

  typedef enum logic [2:0] {
    NXT_STEP = 3'd0,
    NXT_WRAP = 3'd1,
    NXT_FFT  = 3'd2,
    NXT_LOAD = 3'd3,
    NXT_NONE = 3'd4
  } nextSel_e;

  typedef struct packed {
    logic     genAddr;
    logic     updPtr;
    logic     loadMod;
    addrSel_e addrSel;
    nextSel_e nextSel;
  } aguCtrl_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  output aguCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{genAddr: 1'b0, updPtr: 1'b0, loadMod: 1'b0,
             addrSel: ADR_PTR, nextSel: NXT_NONE};
    if (reqValid) begin
      case (aguMode_e'(reqMode))
        MODE_FIXED: begin
          ctrl.genAddr = 1'b1;
          ctrl.addrSel = ADR_PTR_OFF;
        end
        MODE_INDIR: begin
          ctrl.genAddr = 1'b1;
          ctrl.addrSel = ADR_PTR_MOD;
        end
        MODE_POSTINC: begin
          ctrl.genAddr = 1'b1;
          ctrl.updPtr  = 1'b1;
          ctrl.nextSel = NXT_STEP;
        end
        MODE_CYCLIC: begin
          ctrl.genAddr = 1'b1;
          ctrl.updPtr  = 1'b1;
          ctrl.nextSel = NXT_WRAP;
        end
        MODE_FFT: begin
          ctrl.genAddr = 1'b1;
          ctrl.updPtr  = 1'b1;
          ctrl.addrSel = ADR_FFT;
          ctrl.nextSel = NXT_FFT;
        end
        MODE_SETPTR: begin
          ctrl.updPtr  = 1'b1;
          ctrl.nextSel = NXT_LOAD;
        end
        MODE_SETMOD: ctrl.loadMod = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int NUM_PTR   = 8,
  parameter int FFT_MAX   = 10,
  parameter int VEC_BYTES = 32,
  localparam int IDX_W    = $clog2(NUM_PTR),
  localparam int FFT_LOG_W = $clog2(FFT_MAX + 1),
  localparam int VEC_SH   = $clog2(VEC_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  aguCtrl_t             ctrl,
  input  logic [IDX_W-1:0]     ptrIdx,
  input  logic [ADDR_W-1:0]    offset,
  input  logic [1:0]           width,
  input  logic [ADDR_W-1:0]    cycBase,
  input  logic [ADDR_W-1:0]    cycSize,
  input  logic [FFT_LOG_W-1:0] fftLog2,
  output logic                 addrValid,
  output logic [ADDR_W-1:0]    addrOut,
  output logic                 alignErr,
  output logic                 wbValid,
  output logic [IDX_W-1:0]     wbIdx,
  output logic [ADDR_W-1:0]    wbData
);

  logic [ADDR_W-1:0] ptrFile [NUM_PTR];
  logic [ADDR_W-1:0] modFile [NUM_PTR];

  logic [ADDR_W-1:0] curPtr, modVal, effAddr, nextPtr;
  logic [ADDR_W-1:0] revPtr, fftMask, stepRed, sizeMask;
  logic [ADDR_W:0]   sumW, endW, wrapW;
  logic [2:0]        sizeSh;
  logic              misaligned;

  function automatic logic [ADDR_W-1:0] revLow(input logic [ADDR_W-1:0] v,
                                                input int k);
    logic [ADDR_W-1:0] r;
    r = '0;
    for (int i = 0; i < FFT_MAX; i++) begin
      if (i < k) r[i] = v[k-1-i];
    end
    return r;
  endfunction

  // Forward a pointer committed one cycle late
  assign curPtr = (wbValid && wbIdx == ptrIdx) ? wbData : ptrFile[ptrIdx];
  assign modVal = modFile[offset[IDX_W-1:0]];

  always_comb begin
    case (width)
      2'd0:    sizeSh = 3'd0;
      2'd1:    sizeSh = 3'd1;
      2'd2:    sizeSh = 3'd2;
      default: sizeSh = 3'(VEC_SH);
    endcase
  end

  assign sizeMask = (ADDR_W'(1) << sizeSh) - ADDR_W'(1);
  assign fftMask  = (ADDR_W'(1) << fftLog2) - ADDR_W'(1);
  assign revPtr   = revLow(curPtr, int'(fftLog2));

  // Circular window arithmetic
  assign stepRed = (cycSize == '0) ? offset : (offset % cycSize);
  assign sumW    = {1'b0, curPtr} + {1'b0, stepRed};
  assign endW    = {1'b0, cycBase} + {1'b0, cycSize};
  assign wrapW   = (cycSize != '0 && sumW >= endW) ? (sumW - {1'b0, cycSize}) : sumW;

  always_comb begin
    case (ctrl.addrSel)
      ADR_PTR_OFF: effAddr = curPtr + offset;
      ADR_PTR_MOD: effAddr = curPtr + modVal;
      ADR_FFT:     effAddr = cycBase + (revPtr << sizeSh);
      default:     effAddr = curPtr;
    endcase
  end

  always_comb begin
    case (ctrl.nextSel)
      NXT_STEP: nextPtr = curPtr + offset;
      NXT_WRAP: nextPtr = wrapW[ADDR_W-1:0];
      NXT_FFT:  nextPtr = (curPtr + ADDR_W'(1)) & fftMask;
      NXT_LOAD: nextPtr = offset;
      default:  nextPtr = curPtr;
    endcase
  end

  assign misaligned = ctrl.genAddr && ((effAddr & sizeMask) != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      addrOut   <= '0;
      alignErr  <= 1'b0;
      wbValid   <= 1'b0;
      wbIdx     <= '0;
      wbData    <= '0;
    end else begin
      addrValid <= ctrl.genAddr && !misaligned;
      addrOut   <= effAddr;
      alignErr  <= misaligned;
      wbValid   <= ctrl.updPtr && !misaligned;
      wbIdx     <= ptrIdx;
      wbData    <= nextPtr;
    end
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_regs
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrFile[g] <= '0;
        modFile[g] <= '0;
      end else begin
        if (wbValid && wbIdx == IDX_W'(g)) ptrFile[g] <= wbData;
        if (ctrl.loadMod && ptrIdx == IDX_W'(g)) modFile[g] <= offset;
      end
    end
  end

endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int NUM_PTR    = 8,
  parameter int FFT_MAX    = 10,
  parameter int VEC_BYTES  = 32,
  localparam int IDX_W     = $clog2(NUM_PTR),
  localparam int FFT_LOG_W = $clog2(FFT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqMode,
  input  logic [IDX_W-1:0]     reqPtrIdx,
  input  logic [ADDR_W-1:0]    reqOffset,
  input  logic [1:0]           reqWidth,
  input  logic [ADDR_W-1:0]    cycBase,
  input  logic [ADDR_W-1:0]    cycSize,
  input  logic [FFT_LOG_W-1:0] fftLog2,
  output logic                 addrValid,
  output logic [ADDR_W-1:0]    addrOut,
  output logic                 alignErr,
  output logic                 ptrWbValid,
  output logic [IDX_W-1:0]     ptrWbIdx,
  output logic [ADDR_W-1:0]    ptrWbData
);

  aguCtrl_t ctrl;

  agu_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .ctrl     (ctrl)
  );

  agu_datapath #(
    .ADDR_W    (ADDR_W),
    .NUM_PTR   (NUM_PTR),
    .FFT_MAX   (FFT_MAX),
    .VEC_BYTES (VEC_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .ptrIdx    (reqPtrIdx),
    .offset    (reqOffset),
    .width     (reqWidth),
    .cycBase   (cycBase),
    .cycSize   (cycSize),
    .fftLog2   (fftLog2),
    .addrValid (addrValid),
    .addrOut   (addrOut),
    .alignErr  (alignErr),
    .wbValid   (ptrWbValid),
    .wbIdx     (ptrWbIdx),
    .wbData    (ptrWbData)
  );

endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk #(
  parameter int ADDR_W    = 20,
  parameter int IDX_W     = 3,
  parameter int FFT_LOG_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [2:0]           reqMode,
  input logic [IDX_W-1:0]     reqPtrIdx,
  input logic [ADDR_W-1:0]    reqOffset,
  input logic [1:0]           reqWidth,
  input logic [ADDR_W-1:0]    cycBase,
  input logic [ADDR_W-1:0]    cycSize,
  input logic [FFT_LOG_W-1:0] fftLog2,
  input logic                 addrValid,
  input logic [ADDR_W-1:0]    addrOut,
  input logic                 alignErr,
  input logic                 ptrWbValid,
  input logic [IDX_W-1:0]     ptrWbIdx,
  input logic [ADDR_W-1:0]    ptrWbData
);

  // R8
  excl_valid_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && alignErr));

  // R8
  err_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> !ptrWbValid);

  // R2
  fixed_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 3'd0) |=> !ptrWbValid);

  // R4
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqMode == 3'd2) && addrValid)
      |-> (ptrWbValid && ptrWbData == addrOut + $past(reqOffset)));

  // R5
  cyclic_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqMode == 3'd3 && cycSize != '0) && ptrWbValid
      && addrOut >= $past(cycBase)
      && {1'b0, addrOut} < {1'b0, $past(cycBase)} + {1'b0, $past(cycSize)})
    |-> (ptrWbData >= $past(cycBase)
      && {1'b0, ptrWbData} < {1'b0, $past(cycBase)} + {1'b0, $past(cycSize)}));

  // R10
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 3'd7) |=> (!addrValid && !alignErr && !ptrWbValid));

endmodule

bind agu_core agu_core_chk #(
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W),
  .FFT_LOG_W (FFT_LOG_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqMode    (reqMode),
  .reqPtrIdx  (reqPtrIdx),
  .reqOffset  (reqOffset),
  .reqWidth   (reqWidth),
  .cycBase    (cycBase),
  .cycSize    (cycSize),
  .fftLog2    (fftLog2),
  .addrValid  (addrValid),
  .addrOut    (addrOut),
  .alignErr   (alignErr),
  .ptrWbValid (ptrWbValid),
  .ptrWbIdx   (ptrWbIdx),
  .ptrWbData  (ptrWbData)
);

// File: tb/agu_core_tb.sv
module agu_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [2:0]  reqPtrIdx = '0;
  logic [19:0] reqOffset = '0;
  logic [1:0]  reqWidth = '0;
  logic [19:0] cycBase = '0;
  logic [19:0] cycSize = '0;
  logic [3:0]  fftLog2 = '0;
  logic        addrValid, alignErr, ptrWbValid;
  logic [19:0] addrOut, ptrWbData;
  logic [2:0]  ptrWbIdx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [19:0] ptrM [8];
  logic [19:0] modM [8];

  always #2 clk = ~clk;

  agu_core u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqPtrIdx(reqPtrIdx), .reqOffset(reqOffset), .reqWidth(reqWidth),
    .cycBase(cycBase), .cycSize(cycSize), .fftLog2(fftLog2),
    .addrValid(addrValid), .addrOut(addrOut), .alignErr(alignErr),
    .ptrWbValid(ptrWbValid), .ptrWbIdx(ptrWbIdx), .ptrWbData(ptrWbData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] bitRev(input logic [19:0] v, input int k);
    logic [19:0] r = '0;
    for (int i = 0; i < k; i++) r[i] = v[k-1-i];
    return r;
  endfunction

  function automatic int sizeShift(input logic [1:0] w);
    case (w)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 2;
      default: return 5;
    endcase
  endfunction

  // Issue one request at a negedge; check outputs at the next negedge.
  task automatic op(input logic [2:0] mode, input logic [2:0] idx,
                    input logic [19:0] off, input logic [1:0] wid,
                    input string req);
    logic [19:0] p, a, np, step;
    logic [20:0] sum;
    bit genA = 0, upd = 0, mis = 0;
    p = ptrM[idx];
    a = p;
    np = p;
    case (mode)
      3'd0: begin genA = 1; a = p + off; end
      3'd1: begin genA = 1; a = p + modM[off[2:0]]; end
      3'd2: begin genA = 1; upd = 1; np = p + off; end
      3'd3: begin
        genA = 1; upd = 1;
        step = (cycSize == 0) ? off : off % cycSize;
        sum = {1'b0, p} + {1'b0, step};
        if (cycSize != 0 && sum >= {1'b0, cycBase} + {1'b0, cycSize})
          sum = sum - {1'b0, cycSize};
        np = sum[19:0];
      end
      3'd4: begin
        genA = 1; upd = 1;
        a = cycBase + (bitRev(p, int'(fftLog2)) << sizeShift(wid));
        np = (p + 20'd1) & ((20'd1 << fftLog2) - 20'd1);
      end
      3'd5: begin upd = 1; np = off; end
      3'd6: modM[idx] = off;
      default: ;
    endcase
    if (genA) mis = (a & ((20'd1 << sizeShift(wid)) - 20'd1)) != 0;
    if (mis) upd = 0;
    if (upd) ptrM[idx] = np;

    reqValid = 1'b1; reqMode = mode; reqPtrIdx = idx;
    reqOffset = off; reqWidth = wid;
    @(negedge clk);
    reqValid = 1'b0;
    chk(addrValid == (genA && !mis), req, "addrValid", 32'(addrValid), 32'(genA && !mis));
    chk(alignErr == mis, req, "alignErr", 32'(alignErr), 32'(mis));
    if (genA && !mis) chk(addrOut == a, req, "addrOut", 32'(addrOut), 32'(a));
    chk(ptrWbValid == upd, req, "ptrWbValid", 32'(ptrWbValid), 32'(upd));
    if (upd) begin
      chk(ptrWbIdx == idx, req, "ptrWbIdx", 32'(ptrWbIdx), 32'(idx));
      chk(ptrWbData == np, req, "ptrWbData", 32'(ptrWbData), 32'(np));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin ptrM[i] = '0; modM[i] = '0; end
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    chk(!addrValid && !alignErr && !ptrWbValid, "R1", "outputs in reset",
        {29'd0, addrValid, alignErr, ptrWbValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: every pointer and modifier reads zero
    for (int i = 0; i < 8; i++) op(3'd0, 3'(i), 20'd0, 2'd2, "R1");
    op(3'd1, 3'd3, 20'd5, 2'd0, "R1");

    // R9 / R2: load then fixed, back to back (forwarding)
    op(3'd5, 3'd1, 20'h01000, 2'd0, "R9");
    op(3'd0, 3'd1, 20'h00024, 2'd2, "R2");
    op(3'd0, 3'd1, 20'h00000, 2'd3, "R2");

    // R3: modifier load then indirect
    op(3'd6, 3'd4, 20'h00300, 2'd0, "R3");
    op(3'd1, 3'd1, 20'h00004, 2'd2, "R3");
    op(3'd0, 3'd1, 20'h00000, 2'd0, "R3");

    // R4 / R9: post-increment chain, same pointer every cycle
    op(3'd2, 3'd1, 20'h00010, 2'd2, "R4");
    op(3'd2, 3'd1, 20'h00010, 2'd2, "R4");
    op(3'd2, 3'd1, 20'h00020, 2'd3, "R9");

    // R8: misaligned post-increment leaves pointer untouched
    op(3'd2, 3'd1, 20'h00004, 2'd2, "R8");
    op(3'd2, 3'd1, 20'h00003, 2'd0, "R8");
    op(3'd2, 3'd1, 20'h00000, 2'd1, "R8");
    op(3'd0, 3'd1, 20'h00000, 2'd0, "R8");

    // R5: cyclic wrap across window end
    cycBase = 20'h00100; cycSize = 20'h00040;
    op(3'd5, 3'd2, 20'h00130, 2'd0, "R5");
    op(3'd3, 3'd2, 20'h00018, 2'd2, "R5");
    op(3'd3, 3'd2, 20'h00018, 2'd2, "R5");
    // R6: step larger than and equal to the window
    op(3'd3, 3'd2, 20'h00050, 2'd2, "R6");
    op(3'd3, 3'd2, 20'h00040, 2'd2, "R6");
    op(3'd3, 3'd2, 20'h000C8, 2'd2, "R6");

    // R7: full 8-point bit-reversed sweep and wrap
    cycBase = 20'h00200; fftLog2 = 4'd3;
    op(3'd5, 3'd5, 20'h00000, 2'd0, "R7");
    for (int i = 0; i < 9; i++) op(3'd4, 3'd5, 20'h0, 2'd2, "R7");

    // R10: reserved mode ignored, state unchanged afterwards
    op(3'd7, 3'd1, 20'hFFFFF, 2'd0, "R10");
    op(3'd0, 3'd1, 20'h00000, 2'd0, "R10");
    op(3'd1, 3'd0, 20'h00004, 2'd0, "R10");

    // Random mix over few pointers
    for (int n = 0; n < 600; n++) begin
      logic [2:0] m = 3'($urandom_range(0, 7));
      logic [19:0] o = 20'($urandom) & ((n % 5 == 0) ? 20'h0FFFF : 20'h0FFFC);
      if (n % 40 == 0) begin
        cycBase = 20'($urandom) & 20'hFFF00;
        cycSize = 20'($urandom_range(0, 255)) & 20'hFFFFC;
        fftLog2 = 4'($urandom_range(0, 10));
      end
      op(m, 3'($urandom_range(0, 3)), o, 2'($urandom_range(0, 3)),
         m == 3'd0 ? "R2" : m == 3'd1 ? "R3" : m == 3'd2 ? "R4" :
         m == 3'd3 ? "R5" : m == 3'd4 ? "R7" : m == 3'd5 ? "R9" :
         m == 3'd6 ? "R3" : "R10");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule